// File: doc/BRIEF.md
# Dual-Bank Flash Image Validator

The validator checks the images stored in two flash banks. It does not store them: a byte stream carries one image at a time, and a bank tag says which bank the image belongs to. While the bytes pass, the block computes three integrity checks:

- the fixed marker byte;
- a folded 8-bit header sum;
- a 32-bit Adler-style word over the tail of the image.

When the image ends, the block records for that bank whether the image is good and what its 32-bit generation counter is. It then names as active the bank that holds the newer image.

A second mode prepares an image for writing. The stream carries the new contents, and the block returns what must be written back:

- the increased generation;
- the header sum computed with the marker byte forced;
- the Adler word computed over the image that holds that new generation;
- the bank to write, which is the one that is not active now.

Upstream logic streams bank 0 and bank 1 after power-up and reads the active-bank output. Before it commits an updated image, it streams that image once in prepare mode.

Top module: `nvram_bank_validator`

## Requirements
- R1: The header fields are read at fixed byte offsets, most significant byte first. The header sum is at offset 1, the stored Adler word at offsets 0x10 to 0x13, and the generation at offsets 0x14 to 0x17.
- R2: An image can be valid only when its byte at offset 0 equals 0x5A.
- R3: The header sum starts with the byte at offset 0 and adds the bytes at offsets 2 to 15 into a 16-bit total. The high byte of the total is then added to the low byte until the result fits in 8 bits. A valid image must hold this result at offset 1.
- R4: The Adler word covers every byte from offset 0x14 up to and including the final byte. It starts with low=1 and high=0. For each byte, low gains the byte and high gains the new low, both modulo 65521. The word is high<<16 | low, and a valid image must hold it at offsets 0x10 to 0x13.
- R5: A checked image sets only the tagged bank's outputs. A valid image reports valid=1 and its generation. An image that fails any check reports valid=0 and a generation of 0.
- R6: activeBank is 1 only when bank 0's generation is strictly less than bank 1's. Equal generations select bank 0.
- R7: A prepare image sets four outputs and leaves the per-bank outputs and activeBank unchanged:
  - sealGen is the generation plus 1, wrapping at 32 bits.
  - sealCksum is the R3 sum with offset 0 taken as 0x5A.
  - sealAdler is the R4 word over the image with sealGen stored at offsets 0x14 to 0x17.
  - sealBank is the inverse of activeBank.
  The bytes at offset 1 and at offsets 0x10 to 0x13 have no effect.
- R8: doneValid is high for exactly one cycle: the cycle after the byte with inLast is accepted. The results have been updated by that cycle, and inReady is low during it.
- R9: When the byte at offset 0x17 is accepted and it is not the last byte, inReady goes low for exactly 4 cycles and then rises again.
- R10: After reset, inReady=1, doneValid=0, both valid flags are 0, both generations are 0 and activeBank=0.
- R11: The bank tag and the mode are taken from the byte at offset 0 only. Their values on later bytes of the same image have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | A stream byte is offered |
| inReady | output | 1 | The block accepts a byte this cycle |
| inData | input | 8 | Stream byte |
| inLast | input | 1 | This byte is the final byte of the image |
| inBank | input | 1 | Bank tag, taken from the byte at offset 0 |
| inSeal | input | 1 | 1 = prepare mode, 0 = check mode, taken from the byte at offset 0 |
| doneValid | output | 1 | Results were updated by the image that just ended |
| bankValid | output | 2 | Per-bank validity flags, bit n for bank n |
| bankGen0 | output | 32 | Reported generation of bank 0 |
| bankGen1 | output | 32 | Reported generation of bank 1 |
| activeBank | output | 1 | Bank that holds the newer image |
| sealCksum | output | 8 | Header sum for the prepared image |
| sealAdler | output | 32 | Adler word for the prepared image |
| sealGen | output | 32 | Increased generation for the prepared image |
| sealBank | output | 1 | Bank that the prepared image should go to |

## Verification
Two situations are hardest to reach from the ports.

The first is a prepare-mode image in which the increase of the generation carries through all four bytes. The values fed into the Adler word during the stall then differ from every streamed generation byte. The bench builds an image whose generation is 0xFFFFFFFF, so the new generation wraps to 0.

The second is the modulo reduction near its limit. The bench streams a full 8 KiB image whose tail bytes are all 0xFF, so both accumulators keep crossing 65521.

Separate images break exactly one of the three checks each, so that every check alone is shown to reject. One image changes its tag and mode on every byte after the first.

// File: rtl/nvv_pkg.sv
package nvv_pkg;
  localparam logic [7:0] SIG_BYTE  = 8'h5A;
  localparam int         ADLER_MOD = 65521;
  localparam int         OFS_CK    = 1;
  localparam int         OFS_HEND  = 15;
  localparam int         OFS_FLD   = 16;
  localparam int         OFS_GEN   = 20;
  localparam int         OFS_TAIL  = 24;

  typedef struct packed {
    logic       take;
    logic       first;
    logic       ckByte;
    logic       sumByte;
    logic       fldByte;
    logic       genByte;
    logic       adlByte;
    logic       replay;
    logic [1:0] replayIdx;
    logic       finish;
  } strobe_t;

  function automatic logic [31:0] adlerStep(logic [31:0] acc, logic [7:0] b);
    logic [16:0] lo;
    logic [16:0] hi;
    lo = {1'b0, acc[15:0]} + {9'd0, b};
    if (lo >= 17'(ADLER_MOD)) lo = lo - 17'(ADLER_MOD);
    hi = {1'b0, acc[31:16]} + lo;
    if (hi >= 17'(ADLER_MOD)) hi = hi - 17'(ADLER_MOD);
    return {hi[15:0], lo[15:0]};
  endfunction

  function automatic logic [7:0] foldSum(logic [15:0] s);
    logic [8:0] f;
    f = {1'b0, s[7:0]} + {1'b0, s[15:8]};
    return f[7:0] + {7'd0, f[8]};
  endfunction
endpackage

// File: rtl/nvv_ctrl.sv
module nvv_ctrl
  import nvv_pkg::*;
#(
  parameter int IMAGE_BYTES = 8192
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    inValid,
  input  logic    inLast,
  output logic    inReady,
  output logic    doneValid,
  output strobe_t stb
);
  localparam int OFF_W = $clog2(IMAGE_BYTES) + 1;

  typedef enum logic [1:0] {ST_STREAM, ST_REPLAY, ST_DONE} state_t;

  state_t           state;
  logic [OFF_W-1:0] offset;
  logic [1:0]       repCnt;

  assign inReady   = (state == ST_STREAM);
  assign doneValid = (state == ST_DONE);

  always_comb begin
    stb           = '0;
    stb.take      = inValid && inReady;
    stb.first     = stb.take && (offset == '0);
    stb.ckByte    = stb.take && (offset == OFF_W'(OFS_CK));
    stb.sumByte   = stb.take && (offset > OFF_W'(OFS_CK)) && (offset <= OFF_W'(OFS_HEND));
    stb.fldByte   = stb.take && (offset >= OFF_W'(OFS_FLD)) && (offset < OFF_W'(OFS_GEN));
    stb.genByte   = stb.take && (offset >= OFF_W'(OFS_GEN)) && (offset < OFF_W'(OFS_TAIL));
    stb.adlByte   = stb.take && (offset >= OFF_W'(OFS_TAIL));
    stb.replay    = (state == ST_REPLAY);
    stb.replayIdx = repCnt;
    stb.finish    = stb.take && inLast;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_STREAM;
      offset <= '0;
      repCnt <= '0;
    end else begin
      case (state)
        ST_STREAM: begin
          if (stb.take) begin
            if (inLast) begin
              state  <= ST_DONE;
              offset <= '0;
            end else begin
              if (offset != '1) offset <= offset + 1'b1;
              if (offset == OFF_W'(OFS_TAIL - 1)) begin
                state  <= ST_REPLAY;
                repCnt <= '0;
              end
            end
          end
        end
        ST_REPLAY: begin
          repCnt <= repCnt + 1'b1;
          if (repCnt == 2'd3) state <= ST_STREAM;
        end
        default: state <= ST_STREAM;
      endcase
    end
  end
endmodule

// File: rtl/nvv_dpath.sv
module nvv_dpath
  import nvv_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  strobe_t     stb,
  input  logic [7:0]  inData,
  input  logic        inBank,
  input  logic        inSeal,
  output logic [1:0]  bankValid,
  output logic [31:0] bankGen0,
  output logic [31:0] bankGen1,
  output logic        activeBank,
  output logic [7:0]  sealCksum,
  output logic [31:0] sealAdler,
  output logic [31:0] sealGen,
  output logic        sealBank
);
  logic             modeSeal;
  logic             bankSel;
  logic [7:0]       sigReg;
  logic [7:0]       ckReg;
  logic [15:0]      hdrAcc;
  logic [31:0]      fldAdler;
  logic [31:0]      genReg;
  logic [31:0]      adlAcc;
  logic [1:0][31:0] gens;
  logic [31:0]      genUse;
  logic [7:0]       repByte;
  logic [7:0]       adlIn;
  logic             adlEn;
  logic [31:0]      adlNext;
  logic             imageOk;

  assign genUse = modeSeal ? genReg + 32'd1 : genReg;

  always_comb begin
    case (stb.replayIdx)
      2'd0:    repByte = genUse[31:24];
      2'd1:    repByte = genUse[23:16];
      2'd2:    repByte = genUse[15:8];
      default: repByte = genUse[7:0];
    endcase
  end

  assign adlIn   = stb.replay ? repByte : inData;
  assign adlEn   = stb.adlByte || stb.replay;
  assign adlNext = adlEn ? adlerStep(adlAcc, adlIn) : adlAcc;
  assign imageOk = (sigReg == SIG_BYTE) && (ckReg == foldSum(hdrAcc)) && (fldAdler == adlNext);

  assign bankGen0   = gens[0];
  assign bankGen1   = gens[1];
  assign activeBank = gens[0] < gens[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeSeal  <= 1'b0;
      bankSel   <= 1'b0;
      sigReg    <= '0;
      ckReg     <= '0;
      hdrAcc    <= '0;
      fldAdler  <= '0;
      genReg    <= '0;
      adlAcc    <= 32'd1;
      gens      <= '0;
      bankValid <= '0;
      sealCksum <= '0;
      sealAdler <= '0;
      sealGen   <= '0;
      sealBank  <= 1'b0;
    end else begin
      if (stb.ckByte)  ckReg    <= inData;
      if (stb.sumByte) hdrAcc   <= hdrAcc + {8'd0, inData};
      if (stb.fldByte) fldAdler <= {fldAdler[23:0], inData};
      if (stb.genByte) genReg   <= {genReg[23:0], inData};
      if (adlEn)       adlAcc   <= adlNext;
      if (stb.first) begin
        modeSeal <= inSeal;
        bankSel  <= inBank;
        sigReg   <= inData;
        hdrAcc   <= inSeal ? {8'd0, SIG_BYTE} : {8'd0, inData};
        adlAcc   <= 32'd1;
      end
      if (stb.finish) begin
        if (modeSeal) begin
          sealCksum <= foldSum(hdrAcc);
          sealAdler <= adlNext;
          sealGen   <= genReg + 32'd1;
          sealBank  <= ~activeBank;
        end else begin
          bankValid[bankSel] <= imageOk;
          gens[bankSel]      <= imageOk ? genReg : 32'd0;
        end
      end
    end
  end
endmodule

// File: rtl/nvram_bank_validator.sv
module nvram_bank_validator
  import nvv_pkg::*;
#(
  parameter int IMAGE_BYTES = 8192
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output logic        inReady,
  input  logic [7:0]  inData,
  input  logic        inLast,
  input  logic        inBank,
  input  logic        inSeal,
  output logic        doneValid,
  output logic [1:0]  bankValid,
  output logic [31:0] bankGen0,
  output logic [31:0] bankGen1,
  output logic        activeBank,
  output logic [7:0]  sealCksum,
  output logic [31:0] sealAdler,
  output logic [31:0] sealGen,
  output logic        sealBank
);
  strobe_t stb;

  nvv_ctrl #(.IMAGE_BYTES(IMAGE_BYTES)) ctrlI (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inLast(inLast),
    .inReady(inReady), .doneValid(doneValid), .stb(stb)
  );

  nvv_dpath dpathI (
    .clk(clk), .rstN(rstN), .stb(stb), .inData(inData), .inBank(inBank),
    .inSeal(inSeal), .bankValid(bankValid), .bankGen0(bankGen0),
    .bankGen1(bankGen1), .activeBank(activeBank), .sealCksum(sealCksum),
    .sealAdler(sealAdler), .sealGen(sealGen), .sealBank(sealBank)
  );
endmodule

// File: rtl/nvram_bank_validator_chk.sv
module nvram_bank_validator_chk (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic        inReady,
  input logic        inLast,
  input logic        doneValid,
  input logic [1:0]  bankValid,
  input logic [31:0] bankGen0,
  input logic [31:0] bankGen1,
  input logic        activeBank
);
  // R8
  done_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> !inReady);

  // R8
  done_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> $past(inValid && inReady && inLast));

  // R5
  gen_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(bankGen0) || !$stable(bankGen1)) |-> doneValid);

  // R5
  invalid_zero0_chk: assert property (@(posedge clk) disable iff (!rstN)
    !bankValid[0] |-> (bankGen0 == 32'd0));

  // R5
  invalid_zero1_chk: assert property (@(posedge clk) disable iff (!rstN)
    !bankValid[1] |-> (bankGen1 == 32'd0));

  // R6
  active_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(activeBank) |-> doneValid);

  // R9
  stall_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(inReady) && !inReady && !doneValid) |=> !inReady);
endmodule

bind nvram_bank_validator nvram_bank_validator_chk chkI (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
  .inLast(inLast), .doneValid(doneValid), .bankValid(bankValid),
  .bankGen0(bankGen0), .bankGen1(bankGen1), .activeBank(activeBank)
);

// File: tb/nvram_bank_validator_tb_top.sv
`timescale 1ns/100ps
module nvram_bank_validator_tb_top;
  localparam int IMG = 8192;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [7:0]  inData = '0;
  logic        inLast = 1'b0;
  logic        inBank = 1'b0;
  logic        inSeal = 1'b0;
  logic        doneValid;
  logic [1:0]  bankValid;
  logic [31:0] bankGen0, bankGen1;
  logic        activeBank;
  logic [7:0]  sealCksum;
  logic [31:0] sealAdler, sealGen;
  logic        sealBank;

  int nChecks = 0;
  int nFail = 0;

  always #2.5 clk = ~clk;

  nvram_bank_validator dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inData(inData), .inLast(inLast), .inBank(inBank), .inSeal(inSeal),
    .doneValid(doneValid), .bankValid(bankValid), .bankGen0(bankGen0),
    .bankGen1(bankGen1), .activeBank(activeBank), .sealCksum(sealCksum),
    .sealAdler(sealAdler), .sealGen(sealGen), .sealBank(sealBank)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int hdrSum(input logic [7:0] q[$]);
    int s = q[0];
    for (int i = 2; i <= 15; i++) s += q[i];
    while (s > 255) s = (s & 255) + (s >> 8);
    return s;
  endfunction

  function automatic logic [31:0] adlerOf(input logic [7:0] q[$]);
    longint lo = 1;
    longint hi = 0;
    for (int i = 20; i < q.size(); i++) begin
      lo = (lo + q[i]) % 65521;
      hi = (hi + lo) % 65521;
    end
    return 32'((hi << 16) | lo);
  endfunction

  // ---------------- behavioural reference model ----------------
  logic [7:0]  mBuf[$];
  logic        mBank, mSeal, mDone;
  int          mStall;
  logic [1:0]  expValid;
  logic [31:0] expGen[2];
  logic [7:0]  expCk;
  logic [31:0] expAdl, expSGen;
  logic        expSBank;

  function automatic logic expActive();
    return expGen[0] < expGen[1];
  endfunction

  task automatic evalImage();
    logic [7:0]  b[$];
    logic [31:0] g;
    logic        ok;
    b = mBuf;
    g = {b[20], b[21], b[22], b[23]};
    if (mSeal) begin
      g = g + 32'd1;
      b[0] = 8'h5A;
      b[20] = g[31:24]; b[21] = g[23:16]; b[22] = g[15:8]; b[23] = g[7:0];
      expCk    = 8'(hdrSum(b));
      expAdl   = adlerOf(b);
      expSGen  = g;
      expSBank = ~expActive();
    end else begin
      ok = (b[0] == 8'h5A) && (int'(b[1]) == hdrSum(b)) &&
           ({b[16], b[17], b[18], b[19]} == adlerOf(b));
      expValid[mBank] = ok;
      expGen[mBank]   = ok ? g : 32'd0;
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mBuf.delete();
      mDone = 1'b0; mStall = 0; expValid = '0;
      expGen[0] = '0; expGen[1] = '0;
      expCk = '0; expAdl = '0; expSGen = '0; expSBank = 1'b0;
    end else if (mDone) begin
      mDone = 1'b0;
    end else if (mStall > 0) begin
      mStall--;
    end else if (inValid) begin
      if (mBuf.size() == 0) begin
        mBank = inBank;
        mSeal = inSeal;
      end
      mBuf.push_back(inData);
      if (inLast) begin
        evalImage();
        mBuf.delete();
        mDone = 1'b1;
      end else if (mBuf.size() == 24) begin
        mStall = 4;
      end
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      chk("R9 inReady", inReady, !mDone && mStall == 0);
      chk("R8 doneValid", doneValid, mDone);
      chk("R5 bankValid", bankValid, expValid);
      chk("R5 bankGen0", bankGen0, expGen[0]);
      chk("R5 bankGen1", bankGen1, expGen[1]);
      chk("R6 activeBank", activeBank, expActive());
      chk("R7 sealCksum", sealCksum, expCk);
      chk("R7 sealAdler", sealAdler, expAdl);
      chk("R7 sealGen", sealGen, expSGen);
      chk("R7 sealBank", sealBank, expSBank);
    end
  end

  // ---------------- stimulus ----------------
  // flaw: 0 none, 1 wrong marker, 2 wrong header sum, 3 corrupted tail
  task automatic buildImage(output logic [7:0] q[$], input int unsigned seed,
                            input logic [31:0] gen, input int flaw, input bit allFF);
    logic [31:0] a;
    int unsigned s = seed;
    q.delete();
    for (int i = 0; i < IMG; i++) begin
      s = s * 32'd1103515245 + 32'd12345;
      q.push_back(allFF ? 8'hFF : s[23:16]);
    end
    q[0] = (flaw == 1) ? 8'hA5 : 8'h5A;
    q[20] = gen[31:24]; q[21] = gen[23:16]; q[22] = gen[15:8]; q[23] = gen[7:0];
    q[1] = 8'(hdrSum(q));
    a = adlerOf(q);
    q[16] = a[31:24]; q[17] = a[23:16]; q[18] = a[15:8]; q[19] = a[7:0];
    if (flaw == 2) q[1] = q[1] ^ 8'h01;
    if (flaw == 3) q[100] = q[100] ^ 8'h01;
  endtask

  task automatic sendImage(input logic [7:0] img[$], input logic bank,
                           input logic seal, input bit scramble);
    for (int i = 0; i < img.size(); i++) begin
      @(negedge clk);
      inValid = 1'b1;
      inData  = img[i];
      inLast  = (i == img.size() - 1);
      inBank  = (scramble && i > 0) ? ~bank : bank;
      inSeal  = (scramble && i > 0) ? ~seal : seal;
      while (!inReady) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    inValid = 1'b0;
    inLast  = 1'b0;
    chk("R8 done after last", doneValid, 1'b1);
    chk("R8 ready low while done", inReady, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL R8 watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    logic [7:0] img[$];
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R10 reset inReady", inReady, 1'b1);
    chk("R10 reset doneValid", doneValid, 1'b0);
    chk("R10 reset bankValid", bankValid, 2'b00);
    chk("R10 reset bankGen0", bankGen0, 32'd0);
    chk("R10 reset activeBank", activeBank, 1'b0);

    buildImage(img, 32'd11, 32'd5, 0, 1'b0);
    sendImage(img, 1'b0, 1'b0, 1'b0);
    chk("R1 bank0 valid", bankValid[0], 1'b1);
    chk("R1 bank0 generation", bankGen0, 32'd5);

    buildImage(img, 32'd22, 32'd9, 0, 1'b0);
    sendImage(img, 1'b1, 1'b0, 1'b0);
    chk("R6 newer bank1 active", activeBank, 1'b1);

    buildImage(img, 32'd33, 32'd20, 1, 1'b0);
    sendImage(img, 1'b1, 1'b0, 1'b0);
    chk("R2 bad marker invalid", bankValid[1], 1'b0);
    chk("R5 invalid generation zero", bankGen1, 32'd0);
    chk("R6 back to bank0", activeBank, 1'b0);

    buildImage(img, 32'd44, 32'd20, 2, 1'b0);
    sendImage(img, 1'b1, 1'b0, 1'b0);
    chk("R3 bad header sum invalid", bankValid[1], 1'b0);

    buildImage(img, 32'd55, 32'd20, 3, 1'b0);
    sendImage(img, 1'b1, 1'b0, 1'b0);
    chk("R4 bad tail invalid", bankValid[1], 1'b0);

    buildImage(img, 32'd66, 32'd30, 0, 1'b1);
    sendImage(img, 1'b1, 1'b0, 1'b0);
    chk("R4 all-FF tail valid", bankValid[1], 1'b1);
    chk("R4 all-FF generation", bankGen1, 32'd30);

    buildImage(img, 32'd77, 32'd5, 0, 1'b0);
    sendImage(img, 1'b1, 1'b0, 1'b0);
    chk("R6 equal generations pick bank0", activeBank, 1'b0);

    buildImage(img, 32'd88, 32'hFFFF_FFFF, 0, 1'b0);
    img[1] = 8'h00; img[16] = 8'h12; img[19] = 8'hEE;
    sendImage(img, 1'b0, 1'b1, 1'b0);
    chk("R7 generation wraps", sealGen, 32'd0);
    chk("R7 target is inactive bank", sealBank, 1'b1);
    chk("R7 bank outputs untouched", bankGen1, 32'd5);

    buildImage(img, 32'd99, 32'd7, 0, 1'b0);
    sendImage(img, 1'b0, 1'b0, 1'b1);
    chk("R11 tag from first byte", bankGen0, 32'd7);
    chk("R11 other bank untouched", bankGen1, 32'd5);
    chk("R11 check mode from first byte", bankValid, 2'b11);

    buildImage(img, 32'd123, 32'd40, 0, 1'b1);
    sendImage(img, 1'b1, 1'b1, 1'b0);
    chk("R7 generation increased", sealGen, 32'd41);

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule